// File: doc/BRIEF.md
# Self-Timed Fall-Through FIFO

A 64-word by 5-bit first-in first-out buffer built as a chain of storage slots instead of pointers and RAM. Every slot carries its own occupancy bit. On each clock a word drops one slot toward the output end if the slot below it is empty, so a hole in the chain climbs one slot per clock toward the input. The first slot of the chain is the input stage and the last one is the output stage. The 62 slots between them form the main storage.

Both ends use a level handshake. The input-ready flag is high while the input stage is empty. Raising the shift-in strobe loads the data bus into that stage. The word then stays there until the strobe is lowered. The output-ready flag is high while the output stage holds a word that has not yet been taken. Raising the shift-out strobe takes that word, and lowering the strobe frees the stage for the next one. Both strobes pass through a synchronizer, and the input data passes through the same synchronizer so that strobe and data stay aligned. Because of these rules, two instances can be chained with no glue logic: the output-ready flag of the first drives the shift-in strobe of the second, and the input-ready flag of the second drives the shift-out strobe of the first.

An asynchronous active-low reset empties every slot. An active-low output enable gates only the data bus. It reports its state on a qualifier output, and the flags keep working whatever its state.

Top module: `ft_fifo`

## Requirements
- R1: The buffer holds exactly 64 words. Once 64 words are stored, the input-ready flag stays low and any further shift-in strobe is discarded: that word never appears at the output.
- R2: The input-ready flag is high exactly while the input stage is empty. When the shift-in strobe is high while the flag is high, the data bus is captured and the flag goes low.
- R3: A captured word stays in the input stage for as long as the shift-in strobe remains high. It moves on only after the strobe falls, and the input-ready flag then rises again if there is room.
- R4: The output-ready flag is high while the output stage holds a word that has not been taken. A high shift-out strobe takes the word and drops the flag. When the strobe falls, the stage is freed, and the flag rises again only when a next word arrives.
- R5: Words leave in the order they were written, including while writes and reads overlap.
- R6: A word written into an empty buffer reaches the output only after falling through all 63 downstream slots, one slot per clock. This takes between 56 and 76 clocks after the shift-in strobe falls.
- R7: When the buffer is full and the shift-in strobe is held high, a read lets a hole climb to the input stage. The hole takes between 56 and 76 clocks after the shift-out strobe falls. The input-ready flag is then high for exactly one clock, and the waiting word is loaded with no new strobe edge.
- R8: A shift-out strobe on an empty buffer has no effect. After the buffer runs empty, the data bus keeps showing the last word that was output.
- R9: Reset low asynchronously empties all slots. It sets the input-ready flag high, the output-ready flag low and the data bus to 0, without waiting for a clock edge.
- R10: While the output enable is high, the data bus reads 0 and the qualifier reads 0. Both flags are unaffected. While the enable is low, the qualifier reads 1 and the bus shows the output-stage word.
- R11: Two chained instances form a 128-word buffer that keeps the write order. A 129th write is discarded.
- R12: When the shift-out strobe is held high on an empty buffer, an arriving word raises the output-ready flag for exactly one clock and is taken. It is released when the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_in_i | input | 1 | Shift-in strobe, active high |
| data_i | input | 5 | Write data |
| in_ready_o | output | 1 | Input stage empty, ready for a word |
| shift_out_i | input | 1 | Shift-out strobe, active high |
| out_ready_o | output | 1 | Output stage holds an untaken word |
| data_o | output | 5 | Output-stage word, 0 while disabled |
| out_en_ni | input | 1 | Output enable, active low |
| data_oe_o | output | 1 | Data bus qualifier, high while enabled |

## Verification
Capture into the input stage and release of the output stage can occur in the same clock. A hole can also climb through a slot in the same clock that a word falls into the slot below it. The bench provokes both by preloading ten words and then running a writer and a reader concurrently: strobes at both ends overlap while the chain is partly full. The scoreboard queue judges the result, because every word read must match the oldest word written and nothing may be lost or duplicated. The chained pair repeats this at both handshake boundaries.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;
  // per-slot control: take a word from above, hand the held word on
  typedef struct packed {
    logic load;
    logic drop;
  } slot_ctl_t;
endpackage

// File: rtl/ft_sync.sv
module ft_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned BITS = W * STAGES;

  logic [BITS-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[BITS-W-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[BITS-1 -: W];
endmodule

// File: rtl/ft_slot.sv
module ft_slot
  import ft_fifo_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  slot_ctl_t    ctl_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (ctl_i.load) begin
      valid_o <= 1'b1;
      q_o     <= d_i;
    end else if (ctl_i.drop) begin
      valid_o <= 1'b0;   // data kept: last word stays visible
    end
  end

  // a word never lands on an occupied slot
  assert_no_clobber_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.load |-> !valid_o);
  // a slot never loses its word without handing it on
  assert_no_silent_loss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ctl_i.drop) |=> valid_o);
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
  import ft_fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 5,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_in_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              in_ready_o,
  input  logic              shift_out_i,
  output logic              out_ready_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              out_en_ni,
  output logic              data_oe_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic              si_s, so_s;
  logic [DATA_W-1:0] din_s;
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] word [DEPTH];
  logic [LAST-1:0]   adv;
  logic              in_hold_q, taken_q;
  logic              capture, release_w;
  slot_ctl_t         ctl [DEPTH];

  // strobe and data share one synchronizer to stay aligned
  ft_sync #(.W(DATA_W + 1), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({shift_in_i, data_i}),
    .q_o   ({si_s, din_s})
  );

  ft_sync #(.W(1), .STAGES(SYNC_STAGES)) u_out_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (shift_out_i),
    .q_o   (so_s)
  );

  assign capture   = si_s && !valid[0] && !in_hold_q;
  assign release_w = taken_q && !so_s;

  always_comb begin
    for (int i = 0; i < int'(LAST); i++) begin
      adv[i] = valid[i] && !valid[i+1];
    end
    adv[0] = adv[0] && !in_hold_q;   // input word waits for strobe low
  end

  generate
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
      logic [DATA_W-1:0] d_in;
      if (i == 0) begin : g_head
        assign ctl[i].load = capture;
        assign d_in        = din_s;
      end else begin : g_body
        assign ctl[i].load = adv[i-1];
        assign d_in        = word[i-1];
      end
      if (i == int'(LAST)) begin : g_tail
        assign ctl[i].drop = release_w;
      end else begin : g_pass
        assign ctl[i].drop = adv[i];
      end
      ft_slot #(.W(DATA_W)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctl_i  (ctl[i]),
        .d_i    (d_in),
        .valid_o(valid[i]),
        .q_o    (word[i])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_hold_q <= 1'b0;
      taken_q   <= 1'b0;
    end else begin
      if (capture)   in_hold_q <= 1'b1;
      else if (!si_s) in_hold_q <= 1'b0;
      if (release_w) taken_q <= 1'b0;
      else if (so_s && valid[LAST]) taken_q <= 1'b1;
    end
  end

  assign in_ready_o  = !valid[0];
  assign out_ready_o = valid[LAST] && !taken_q;
  assign data_oe_o   = !out_en_ni;
  assign data_o      = out_en_ni ? '0 : word[LAST];

  assert_load_drops_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> !in_ready_o);
  assert_input_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hold_q && si_s) |=> (valid[0] && $stable(word[0])));
  assert_take_drops_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_o && so_s) |=> !out_ready_o);
  assert_untaken_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid[LAST] && !taken_q) |=> valid[LAST]);
  assert_last_word_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv[LAST-1] |=> $stable(word[LAST]));
  always_comb begin
    if (out_en_ni) assert_disabled_bus_R10: assert (data_o == '0 && !data_oe_o);
  end
endmodule

// File: tb/ft_fifo_test.sv
module ft_fifo_test;
  localparam int DW = 5;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, si, so, oe_n;
  logic [DW-1:0] din, dq;
  logic dir, dor, dq_oe;

  ft_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(si), .data_i(din),
    .in_ready_o(dir), .shift_out_i(so), .out_ready_o(dor),
    .data_o(dq), .out_en_ni(oe_n), .data_oe_o(dq_oe)
  );

  // chained pair
  logic c_si, c_so;
  logic [DW-1:0] c_din, c_qa, c_qb;
  logic c_dir_a, c_dor_a, c_dir_b, c_dor_b, c_oe_a, c_oe_b;

  ft_fifo u_a (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(c_si), .data_i(c_din),
    .in_ready_o(c_dir_a), .shift_out_i(c_dir_b), .out_ready_o(c_dor_a),
    .data_o(c_qa), .out_en_ni(1'b0), .data_oe_o(c_oe_a)
  );
  ft_fifo u_b (
    .clk_i(clk), .rst_ni(rst_n), .shift_in_i(c_dor_a), .data_i(c_qa),
    .in_ready_o(c_dir_b), .shift_out_i(c_so), .out_ready_o(c_dor_b),
    .data_o(c_qb), .out_en_ni(1'b0), .data_oe_o(c_oe_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] casc_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: load one word, record it as expected
  task automatic push(input logic [DW-1:0] d);
    int t = 0;
    while (!dir && t < 800) begin @(negedge clk); t++; end
    check(dir, "R2 ready before load", dir, 1);
    si = 1'b1; din = d;
    t = 0;
    do begin @(negedge clk); t++; end while (dir && t < 20);
    check(!dir, "R2 load clears ready", dir, 0);
    si = 1'b0;
    exp_q.push_back(d);
    @(negedge clk);
  endtask

  // monitor: take one word, compare with oldest expected
  task automatic pop();
    int t = 0;
    logic [DW-1:0] e;
    while (!dor && t < 800) begin @(negedge clk); t++; end
    check(dor, "R4 output ready", dor, 1);
    if (exp_q.size() == 0) begin
      check(1'b0, "R5 unexpected word", dq, 0);
      e = '0;
    end else begin
      e = exp_q.pop_front();
      check(dq == e, "R5 word order", dq, e);
    end
    so = 1'b1;
    t = 0;
    do begin @(negedge clk); t++; end while (dor && t < 20);
    check(!dor, "R4 strobe drops ready", dor, 0);
    so = 1'b0;
    @(negedge clk);
  endtask

  task automatic c_push(input logic [DW-1:0] d);
    int t = 0;
    while (!c_dir_a && t < 1000) begin @(negedge clk); t++; end
    check(c_dir_a, "R11 chain ready before load", c_dir_a, 1);
    c_si = 1'b1; c_din = d;
    t = 0;
    do begin @(negedge clk); t++; end while (c_dir_a && t < 20);
    c_si = 1'b0;
    casc_q.push_back(d);
    @(negedge clk);
  endtask

  task automatic c_pop();
    int t = 0;
    logic [DW-1:0] e;
    while (!c_dor_b && t < 1000) begin @(negedge clk); t++; end
    check(c_dor_b, "R11 chain output ready", c_dor_b, 1);
    e = (casc_q.size() != 0) ? casc_q.pop_front() : '0;
    check(c_qb == e, "R11 chain order", c_qb, e);
    c_so = 1'b1;
    t = 0;
    do begin @(negedge clk); t++; end while (c_dor_b && t < 20);
    c_so = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt, first_at, pulses;
    logic [DW-1:0] last_w;
    rst_n = 1'b0; si = 1'b0; so = 1'b0; oe_n = 1'b0; din = '0;
    c_si = 1'b0; c_so = 1'b0; c_din = '0;
    cyc(3);
    // R9: reset state
    check(dir, "R9 reset ready high", dir, 1);
    check(!dor, "R9 reset output low", dor, 0);
    check(dq == 0, "R9 reset data zero", dq, 0);
    check(dq_oe, "R10 qualifier when enabled", dq_oe, 1);
    rst_n = 1'b1;
    cyc(4);

    // R3 + R6: word held while strobe high, then falls through
    si = 1'b1; din = 5'h15;
    cyc(10);
    check(!dir, "R3 word held in input stage", dir, 0);
    cyc(80);
    check(!dor, "R3 no fall-through while strobe high", dor, 0);
    si = 1'b0;
    exp_q.push_back(5'h15);
    cnt = 0;
    while (!dor && cnt < 200) begin @(negedge clk); cnt++; end
    check(cnt >= DEPTH - 8 && cnt <= DEPTH + 12, "R6 fall-through latency", cnt, DEPTH);
    check(dir, "R3 ready again with room", dir, 1);
    pop();
    cyc(10);
    check(!dor, "R4 no ready when empty", dor, 0);
    check(dq == 5'h15, "R8 last word kept", dq, 5'h15);

    // R8: shift-out on empty buffer
    so = 1'b1; cyc(3); so = 1'b0;
    cyc(10);
    check(!dor, "R8 empty read no ready", dor, 0);
    check(dq == 5'h15, "R8 empty read keeps bus", dq, 5'h15);

    // R1: fill to capacity
    for (int i = 0; i < DEPTH; i++) push(5'((i * 7 + 3) % 32));
    cyc(100);
    check(!dir, "R1 full clears ready", dir, 0);
    check(dor, "R4 full shows ready", dor, 1);
    si = 1'b1; din = 5'h1E; cyc(4); si = 1'b0;
    cyc(10);
    check(!dir, "R1 overflow ignored", dir, 0);

    // R7: strobe held high on full buffer, one read
    si = 1'b1; din = 5'h1F;
    cyc(6);
    check(!dir, "R7 no load while full", dir, 0);
    pop();
    pulses = 0; first_at = -1;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (dir) begin
        pulses++;
        if (first_at < 0) first_at = k + 1;
      end
    end
    check(pulses == 1, "R7 single ready pulse", pulses, 1);
    check(first_at >= DEPTH - 8 && first_at <= DEPTH + 12, "R7 hole climb latency", first_at, DEPTH);
    si = 1'b0;
    exp_q.push_back(5'h1F);
    cyc(10);

    // R10: output enable
    oe_n = 1'b1;
    @(negedge clk);
    check(dq == 0, "R10 disabled bus zero", dq, 0);
    check(!dq_oe, "R10 disabled qualifier", dq_oe, 0);
    check(dor && !dir, "R10 flags unaffected", {dor, dir}, 2);
    oe_n = 1'b0;
    @(negedge clk);
    check(dq == exp_q[0], "R10 enabled bus shows word", dq, exp_q[0]);

    // drain: R1 discarded word must not appear, R5 order
    for (int i = 0; i < DEPTH; i++) pop();
    last_w = 5'h1F;
    cyc(100);
    check(!dor && dir, "R4 drained buffer empty", {dor, dir}, 1);
    check(dq == last_w, "R8 last word after drain", dq, last_w);

    // R12: strobe held high on empty buffer
    so = 1'b1;
    cyc(5);
    push(5'h0A);
    pulses = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (dor) pulses++;
    end
    check(pulses == 1, "R12 single output pulse", pulses, 1);
    check(dq == 5'h0A, "R12 taken word on bus", dq, 5'h0A);
    so = 1'b0;
    void'(exp_q.pop_front());
    cyc(8);
    check(!dor && dir, "R12 released and empty", {dor, dir}, 1);

    // R5: overlapping writes and reads
    for (int i = 0; i < 10; i++) push(5'(i + 1));
    fork
      for (int i = 0; i < 30; i++) push(5'((i * 5 + 11) % 32));
      for (int i = 0; i < 30; i++) pop();
    join
    for (int i = 0; i < 10; i++) pop();
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    // R9: asynchronous reset mid-stream
    for (int i = 0; i < 3; i++) push(5'(i + 20));
    cyc(100);
    #2 rst_n = 1'b0;
    #1;
    check(dir, "R9 async ready high", dir, 1);
    check(!dor, "R9 async output low", dor, 0);
    check(dq == 0, "R9 async data zero", dq, 0);
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(4);

    // R11: chained pair, 128 words
    for (int i = 0; i < 2 * DEPTH; i++) c_push(5'((i * 3 + 1) % 32));
    cyc(400);
    check(!c_dir_a, "R11 chain full at 128", c_dir_a, 0);
    check(c_dor_b, "R11 chain output ready", c_dor_b, 1);
    c_si = 1'b1; c_din = 5'h1D; cyc(4); c_si = 1'b0;
    cyc(20);
    check(!c_dir_a, "R11 chain overflow ignored", c_dir_a, 0);
    for (int i = 0; i < 2 * DEPTH; i++) c_pop();
    cyc(300);
    check(!c_dor_b, "R11 chain empty after 128", c_dor_b, 0);
    finish_run();
  end
endmodule